// File: doc/BRIEF.md
# Two-Phase Fence Slot Programmer

This block loads one slot of a file of 64-bit tiling fence registers through a 32-bit register write port. A caller hands over a request naming the slot, the surface base address, its size in bytes, its row stride in bytes, its tiling layout and whether the slot is to be cleared instead. The block builds the two 32-bit halves of the fence word and emits them as ordered writes. It waits for the target's acknowledge on each write before it starts the next one. A one-cycle `done` pulse marks the end of the sequence.

A 64-bit register cannot be updated in one step over a 32-bit port. The sequence is therefore ordered so that the slot never holds a valid-looking mix of old and new halves. The low half, which carries the valid flag, is zeroed first. The high half is written next. The low half is written again, with the valid flag set, as the last step.

The end address is rounded down to a whole number of tile rows. A tile row is eight stride-lengths for the X layout and thirty-two for the Y layout. A small iterative remainder unit computes the rounding, and it runs while the first, zeroing write is in flight.

Top module: `fence_prog`

## Requirements
- R1: `req_ready` is high only while no sequence is running. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. A request held on `req_valid` while the block is busy is not taken.
- R2: The first write of every accepted, well-formed request goes to the slot's low address with data zero. No write to the high address comes before that zeroing write has been acknowledged.
- R3: A clear request (`req_clear`=1) produces exactly two writes: zero to the low address, then zero to the high address. The other request fields are not checked and do not matter.
- R4: Once `wr_valid` rises, it stays high with `wr_addr` and `wr_data` unchanged until a cycle in which `wr_ack` is high. The write completes in that cycle, and the next write starts no earlier than the following cycle.
- R5: The low address of slot `s` is `REG_BASE + 8*s`, and the high address is that value plus 4.
- R6: On an enable, three writes go out in this order: low zero, high word, low word.
  - A tile row is `stride*32` bytes for Y (mode code 2) and `stride*8` bytes for X (mode code 1).
  - `rsize` is `size` rounded down to a multiple of the tile row.
  - The high word is `(base + rsize - 4096)`, taken modulo 2^32, with bits [11:0] cleared.
- R7: The final low word of an enable is laid out as follows:
  - bits [31:12] hold `base[31:12]`;
  - `(stride/128 - 1)` sits at bit `PITCH_SHIFT` with width `PITCH_W`;
  - bit 1 is 1 for Y tiling;
  - bit 0, the valid flag, is 1;
  - every other bit is 0.
- R8: An enable is malformed if the stride is zero, the stride is not a multiple of 128, or the mode is 0 (none) or 3 (reserved). A malformed enable issues no write, pulses `err` for one cycle in the cycle after acceptance, and leaves `req_ready` high.
- R9: `done` pulses for exactly one cycle, in the cycle after the final write's acknowledge. `done` and `err` are never high together.
- R10: After reset, `req_ready`=1, `wr_valid`=0, `done`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_slot | input | SLOT_W | Slot index |
| req_base | input | W | Surface base address |
| req_size | input | W | Surface size in bytes |
| req_stride | input | STRIDE_W | Row stride in bytes |
| req_mode | input | 2 | Tiling layout: 0 none, 1 X, 2 Y, 3 reserved |
| req_clear | input | 1 | Clear the slot instead of enabling it |
| wr_valid | output | 1 | Register write pending |
| wr_ack | input | 1 | Target has completed the pending write |
| wr_addr | output | ADDR_W | Register byte address |
| wr_data | output | 32 | Register write data |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | One-cycle pulse for a rejected enable |

## Verification
The bench stresses the following corner cases:
- sizes that are not a multiple of the tile row, and a size smaller than one row, where the end address falls one page below the base. A design that rounds up, skips the rounding, or uses the wrong row multiplier for Y gives a wrong high word.
- acknowledges delayed by several cycles. A sequencer that moves on without waiting either drops a write or changes address while a write is still pending.
- requests held on `req_valid` while the block is busy. A design that takes them corrupts the queue of expected writes.
- clears that carry junk fields, and each malformed-enable case. A design that writes a third word on a clear, or writes anything for a rejected enable, produces an unexpected write. A design that puts the valid flag in an early write shows the wrong data in the first low-word write.

// File: rtl/fence_pkg.sv
// Shared types for the fence slot programmer.
// Assumes nothing beyond the encodings listed here.
package fence_pkg;

    typedef enum logic [1:0] {
        TILE_NONE = 2'd0,
        TILE_X    = 2'd1,
        TILE_Y    = 2'd2,
        TILE_RSVD = 2'd3
    } tile_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CLR_LO,
        SQ_WAIT_ROW,
        SQ_HI,
        SQ_LO
    } seq_state_e;

endpackage

// File: rtl/fence_req_check.sv
// Judges whether a request may be carried out.
// A clear is always accepted. An enable needs a nonzero stride that is a
// multiple of 128 and a tiling layout of X or Y.
module fence_req_check
    import fence_pkg::*;
#(
    parameter int STRIDE_W = 17
) (
    input  logic [STRIDE_W-1:0] stride,
    input  logic [1:0]          mode,
    input  logic                clear,
    output logic                ok
);

    // Well-formedness decision for one request.
    always_comb begin
        ok = clear ||
             ((stride != '0) && (stride[6:0] == 7'd0) &&
              ((mode == TILE_X) || (mode == TILE_Y)));
    end

endmodule

// File: rtl/fence_row_rem.sv
// Iterative restoring remainder: rem = dividend mod divisor.
// Takes W cycles after start, and fin stays high until the next start.
// Assumes the divisor is nonzero whenever start is asserted.
module fence_row_rem #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] rem
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     dvd_q;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fin_q;
    logic [W:0]       trial;

    // Shift the next dividend bit into the partial remainder.
    always_comb begin
        trial = {rem_q, dvd_q[W-1]};
    end

    // One quotient bit per cycle: subtract the divisor when it fits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else if (start) begin
            dvd_q <= dividend;
            dvs_q <= divisor;
            rem_q <= '0;
            cnt_q <= CNT_W'(W);
            fin_q <= 1'b0;
        end else if (cnt_q != '0) begin
            if (trial >= {1'b0, dvs_q}) begin
                rem_q <= W'(trial - {1'b0, dvs_q});
            end else begin
                rem_q <= trial[W-1:0];
            end
            dvd_q <= dvd_q << 1;
            cnt_q <= cnt_q - 1'b1;
            fin_q <= (cnt_q == CNT_W'(1));
        end
    end

    assign fin = fin_q;
    assign rem = rem_q;

    // A finished remainder is always below the divisor.
    assert_rem_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (rem_q < dvs_q));

    // The unit never reports finished while bits remain to be processed.
    assert_fin_after_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> !fin_q);

endmodule

// File: rtl/fence_word_pack.sv
// Builds the two 32-bit halves of a fence word from latched request fields.
// Assumes PITCH_SHIFT + PITCH_W <= 12, so the pitch field stays below the page bits.
module fence_word_pack #(
    parameter int W           = 32,
    parameter int STRIDE_W    = 17,
    parameter int PITCH_SHIFT = 2,
    parameter int PITCH_W     = 10
) (
    input  logic [W-1:0]        base,
    input  logic [W-1:0]        rsize,
    input  logic [STRIDE_W-1:0] stride,
    input  logic                y_tile,
    output logic [W-1:0]        hi_word,
    output logic [W-1:0]        lo_word
);

    localparam logic [W-1:0] PAGE_MASK = {{(W-12){1'b1}}, 12'd0};
    localparam logic [W-1:0] PAGE      = W'(4096);

    logic [PITCH_W-1:0] pitch;

    // Pitch in 128-byte units, minus one.
    always_comb begin
        pitch = PITCH_W'((stride >> 7) - 1'b1);
    end

    // Last page of the surface, and the start word with its flags.
    always_comb begin
        hi_word = (base + rsize - PAGE) & PAGE_MASK;
        lo_word = (base & PAGE_MASK)
                | (W'(pitch) << PITCH_SHIFT)
                | (W'(y_tile) << 1)
                | W'(1);
    end

endmodule

// File: rtl/fence_seq.sv
// Issues the ordered register writes for one request and waits for an
// acknowledge on each one. A clear gives low zero then high zero. An enable
// gives low zero, then (once the row remainder is ready) the high word, then
// the low word. Assumes REG_BASE is 8-byte aligned.
module fence_seq
    import fence_pkg::*;
#(
    parameter int              SLOT_W   = 4,
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_BASE = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_ok,
    input  logic              req_clear,
    input  logic [SLOT_W-1:0] slot_q,
    input  logic              row_fin,
    input  logic [31:0]       hi_word,
    input  logic [31:0]       lo_word,
    input  logic              wr_ack,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              idle,
    output logic              done,
    output logic              err
);

    seq_state_e state;
    logic       clr_q;
    logic       done_q;
    logic       err_q;
    logic       low_safe;
    logic       hi_sel;

    // Step through the write order, advancing on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            clr_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            low_safe <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                SQ_IDLE: if (accept) begin
                    if (!req_ok) begin
                        err_q <= 1'b1;
                    end else begin
                        clr_q <= req_clear;
                        state <= SQ_CLR_LO;
                    end
                end
                SQ_CLR_LO: if (wr_ack) begin
                    low_safe <= 1'b1;
                    state    <= clr_q ? SQ_HI : SQ_WAIT_ROW;
                end
                SQ_WAIT_ROW: if (row_fin) begin
                    state <= SQ_HI;
                end
                SQ_HI: if (wr_ack) begin
                    if (clr_q) begin
                        state    <= SQ_IDLE;
                        done_q   <= 1'b1;
                        low_safe <= 1'b0;
                    end else begin
                        state <= SQ_LO;
                    end
                end
                SQ_LO: if (wr_ack) begin
                    state    <= SQ_IDLE;
                    done_q   <= 1'b1;
                    low_safe <= 1'b0;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Drive the bus from the current step.
    always_comb begin
        wr_valid = 1'b0;
        wr_data  = '0;
        hi_sel   = 1'b0;
        case (state)
            SQ_CLR_LO: wr_valid = 1'b1;
            SQ_HI: begin
                wr_valid = 1'b1;
                hi_sel   = 1'b1;
                wr_data  = clr_q ? 32'd0 : hi_word;
            end
            SQ_LO: begin
                wr_valid = 1'b1;
                wr_data  = lo_word;
            end
            default: ;
        endcase
        wr_addr = REG_BASE + (ADDR_W'(slot_q) << 3) + (hi_sel ? ADDR_W'(4) : ADDR_W'(0));
    end

    assign idle = (state == SQ_IDLE);
    assign done = done_q;
    assign err  = err_q;

    // A pending write keeps its address and data until acknowledged.
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // The request side is closed while a write is pending.
    assert_busy_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !idle);

    // The high half is touched only after the low half has been zeroed.
    assert_hi_after_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr[2]) |-> low_safe);

    // A rejected request issues no write.
    assert_err_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !wr_valid);

    // Completion and rejection are never reported together.
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

// File: rtl/fence_prog.sv
// Top of the fence slot programmer. Latches a request on acceptance, starts
// the tile-row remainder for enables, and lets the sequencer emit the writes.
// Assumes the write target holds wr_ack low unless wr_valid is high.
module fence_prog
    import fence_pkg::*;
#(
    parameter int                SLOT_W      = 4,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] REG_BASE    = 16'h4000,
    parameter int                STRIDE_W    = 17,
    parameter int                PITCH_SHIFT = 2,
    parameter int                PITCH_W     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SLOT_W-1:0]   req_slot,
    input  logic [31:0]         req_base,
    input  logic [31:0]         req_size,
    input  logic [STRIDE_W-1:0] req_stride,
    input  logic [1:0]          req_mode,
    input  logic                req_clear,
    output logic                wr_valid,
    input  logic                wr_ack,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [31:0]         wr_data,
    output logic                done,
    output logic                err
);

    localparam int W = 32;

    logic                accept;
    logic                req_ok;
    logic                idle;
    logic                row_fin;
    logic [W-1:0]        row_len;
    logic [W-1:0]        row_rem;
    logic [W-1:0]        rsize;
    logic [W-1:0]        hi_word;
    logic [W-1:0]        lo_word;
    logic [SLOT_W-1:0]   slot_q;
    logic [W-1:0]        base_q;
    logic [W-1:0]        size_q;
    logic [STRIDE_W-1:0] stride_q;
    logic                y_q;

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    // Tile row length of the incoming request.
    always_comb begin
        row_len = (req_mode == TILE_Y) ? (W'(req_stride) << 5) : (W'(req_stride) << 3);
        rsize   = size_q - row_rem;
    end

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= '0;
            base_q   <= '0;
            size_q   <= '0;
            stride_q <= '0;
            y_q      <= 1'b0;
        end else if (accept) begin
            slot_q   <= req_slot;
            base_q   <= req_base;
            size_q   <= req_size;
            stride_q <= req_stride;
            y_q      <= (req_mode == TILE_Y);
        end
    end

    fence_req_check #(.STRIDE_W(STRIDE_W)) u_check (
        .stride (req_stride),
        .mode   (req_mode),
        .clear  (req_clear),
        .ok     (req_ok)
    );

    fence_row_rem #(.W(W)) u_rem (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && req_ok && !req_clear),
        .dividend (req_size),
        .divisor  (row_len),
        .fin      (row_fin),
        .rem      (row_rem)
    );

    fence_word_pack #(
        .W           (W),
        .STRIDE_W    (STRIDE_W),
        .PITCH_SHIFT (PITCH_SHIFT),
        .PITCH_W     (PITCH_W)
    ) u_pack (
        .base    (base_q),
        .rsize   (rsize),
        .stride  (stride_q),
        .y_tile  (y_q),
        .hi_word (hi_word),
        .lo_word (lo_word)
    );

    fence_seq #(
        .SLOT_W   (SLOT_W),
        .ADDR_W   (ADDR_W),
        .REG_BASE (REG_BASE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_ok    (req_ok),
        .req_clear (req_clear),
        .slot_q    (slot_q),
        .row_fin   (row_fin),
        .hi_word   (hi_word),
        .lo_word   (lo_word),
        .wr_ack    (wr_ack),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .idle      (idle),
        .done      (done),
        .err       (err)
    );

endmodule

// File: tb/sim_fence_prog.sv
`timescale 1ns/1ps
module sim_fence_prog;

    localparam int          SLOT_W      = 4;
    localparam int          ADDR_W      = 16;
    localparam logic [15:0] REG_BASE    = 16'h4000;
    localparam int          STRIDE_W    = 17;
    localparam int          PITCH_SHIFT = 2;
    localparam int          PITCH_W     = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [SLOT_W-1:0]   req_slot = '0;
    logic [31:0]         req_base = '0;
    logic [31:0]         req_size = '0;
    logic [STRIDE_W-1:0] req_stride = '0;
    logic [1:0]          req_mode = '0;
    logic                req_clear = 1'b0;
    logic                wr_valid;
    logic                wr_ack = 1'b0;
    logic [ADDR_W-1:0]   wr_addr;
    logic [31:0]         wr_data;
    logic                done;
    logic                err;

    always #2 clk = ~clk;

    fence_prog u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_slot (req_slot), .req_base (req_base), .req_size (req_size),
        .req_stride (req_stride), .req_mode (req_mode), .req_clear (req_clear),
        .wr_valid (wr_valid), .wr_ack (wr_ack), .wr_addr (wr_addr), .wr_data (wr_data),
        .done (done), .err (err)
    );

    int checks = 0;
    int fails  = 0;
    int ack_delay = 0;
    int wait_cnt  = 0;
    bit model_ready = 1'b1;
    bit can_accept  = 1'b1;
    bit exp_done = 1'b0;
    bit exp_err  = 1'b0;
    bit held     = 1'b0;
    logic [15:0] qa[$];
    logic [31:0] qd[$];
    string       qt[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // One clock of the reference model: compare outputs, then decide the acknowledge.
    task automatic step();
        @(negedge clk);
        chk(req_ready === model_ready, "R1", req_ready, model_ready);
        chk(done === exp_done, "R9", done, exp_done);
        chk(err === exp_err, "R8", err, exp_err);
        if (held) chk(wr_valid === 1'b1, "R4", wr_valid, 1);
        can_accept = model_ready;
        exp_done = 1'b0;
        exp_err  = 1'b0;
        wr_ack   = 1'b0;
        if (wr_valid) begin
            if (qa.size() == 0) begin
                chk(1'b0, "R8", wr_valid, 0);
            end else begin
                chk(wr_addr === qa[0], "R5", wr_addr, qa[0]);
                chk(wr_data === qd[0], qt[0], wr_data, qd[0]);
                if (wait_cnt >= ack_delay) begin
                    wr_ack = 1'b1;
                    wait_cnt = 0;
                    void'(qa.pop_front());
                    void'(qd.pop_front());
                    void'(qt.pop_front());
                    if (qa.size() == 0) begin
                        exp_done = 1'b1;
                        model_ready = 1'b1;
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
        held = wr_valid && !wr_ack;
    endtask

    // Present one request, predict its writes from the requirements, wait for acceptance.
    task automatic issue(input int slot, input logic [31:0] base, input logic [31:0] size,
                         input int stride, input int mode, input bit clr);
        logic [15:0] a;
        longint      row;
        longint      rs;
        logic [31:0] hi;
        logic [31:0] lo;
        bit          ok;
        while (!can_accept) step();
        req_slot = SLOT_W'(slot);
        req_base = base;
        req_size = size;
        req_stride = STRIDE_W'(stride);
        req_mode = 2'(mode);
        req_clear = clr;
        req_valid = 1'b1;
        ok = clr || (stride != 0 && (stride % 128) == 0 && (mode == 1 || mode == 2));
        a = REG_BASE + 16'(slot * 8);
        if (!ok) begin
            exp_err = 1'b1;
        end else begin
            model_ready = 1'b0;
            qa.push_back(a); qd.push_back(32'd0); qt.push_back("R2");
            if (clr) begin
                qa.push_back(a + 16'd4); qd.push_back(32'd0); qt.push_back("R3");
            end else begin
                row = longint'(stride) * ((mode == 2) ? 32 : 8);
                rs  = (longint'(size) / row) * row;
                hi  = (base + 32'(rs) - 32'd4096) & 32'hFFFF_F000;
                lo  = (base & 32'hFFFF_F000)
                    | (32'((stride / 128 - 1) % (1 << PITCH_W)) << PITCH_SHIFT)
                    | ((mode == 2) ? 32'd2 : 32'd0) | 32'd1;
                qa.push_back(a + 16'd4); qd.push_back(hi); qt.push_back("R6");
                qa.push_back(a);         qd.push_back(lo); qt.push_back("R7");
            end
        end
        step();
        req_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R10", req_ready, 1);
        chk(wr_valid === 1'b0, "R10", wr_valid, 0);
        chk(done === 1'b0, "R10", done, 0);
        chk(err === 1'b0, "R10", err, 0);
        rst_n = 1'b1;
        step();

        ack_delay = 0;
        issue(0, 32'h0010_0000, 32'h0002_0000, 512, 1, 1'b0);   // X, exact rows
        ack_delay = 2;
        issue(3, 32'h0040_0000, 32'h0003_0800, 1536, 2, 1'b0);  // Y, rounded down
        // R1: request held while busy must not be taken
        req_slot = 4'd9; req_base = 32'hDEAD_0000; req_size = 32'h1000;
        req_stride = 17'd128; req_mode = 2'd1; req_clear = 1'b0; req_valid = 1'b1;
        repeat (4) step();
        req_valid = 1'b0;
        ack_delay = 1;
        issue(15, 32'hFFFF_FFFF, 32'h1234_5678, 77, 0, 1'b1);   // R3 clear, junk fields
        issue(2, 32'h0020_0000, 32'h0001_0000, 200, 1, 1'b0);   // R8 stride not multiple
        issue(2, 32'h0020_0000, 32'h0001_0000, 256, 0, 1'b0);   // R8 mode none
        issue(2, 32'h0020_0000, 32'h0001_0000, 0,   2, 1'b0);   // R8 zero stride
        issue(2, 32'h0020_0000, 32'h0001_0000, 256, 3, 1'b0);   // R8 reserved mode
        ack_delay = 0;
        issue(7, 32'h0080_0000, 32'h0000_1000, 4096, 2, 1'b0);  // R6 size below one row
        ack_delay = 3;
        issue(12, 32'h0123_4567, 32'h0400_0000, 130944, 1, 1'b0); // R7 unaligned base, max pitch
        issue(5, 32'h0200_0000, 32'h0000_8000, 128, 2, 1'b0);   // back-to-back, min pitch
        issue(5, 32'h0, 32'h0, 0, 0, 1'b1);                     // R3 clear
        while (!can_accept) step();
        repeat (5) step();
        summary();
        $finish;
    end

endmodule